// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits between one processor and a small word-addressed memory and gives that processor a lock-free way to do an atomic update. A load-linked request reads a word and records its address as a reservation. A later store-conditional to the same address writes memory only if nothing has broken the reservation in the meantime. It reports 1 when the write took place and 0 when it did not. Software retries the load-linked / modify / store-conditional sequence until the status is 1.

Three kinds of event break the reservation. The first is a context switch. The second is a taken interrupt. The third is a snooped write or invalidation from another agent that lands in the same 4-word block as the reserved address. Every store-conditional also consumes the reservation, whether it succeeds or not. Plain loads and stores pass straight through to memory. Each request is answered one cycle later.

Top module: `llsc_monitor_top`

## Requirements
- R1: A load-linked (op code 2'b10) returns the addressed memory word on `rsp_rdata` one cycle after the request and arms a reservation on that word address.
- R2: A plain load (op 2'b00) returns the addressed word one cycle later. A plain store (op 2'b01) always writes memory and leaves the reservation unchanged. Every request raises `rsp_valid` for exactly the following cycle.
- R3: A store-conditional (op 2'b11) whose address equals the armed reservation address writes `req_wdata` to memory and returns `rsp_sc_ok`=1 one cycle later.
- R4: A store-conditional with no armed reservation returns `rsp_sc_ok`=0 and leaves memory unchanged.
- R5: Every store-conditional disarms the reservation, so a second store-conditional with no new load-linked fails.
- R6: `ctx_switch` high in a cycle disarms the reservation.
- R7: `irq_taken` high in a cycle disarms the reservation.
- R8: A snoop whose word address lies in the reserved 4-word block (address bits [4:2] equal) disarms the reservation. A snoop to any other block has no effect on it.
- R9: A snoop to the reserved block in the same cycle as a store-conditional makes that store-conditional fail. A clearing event in the same cycle as a load-linked leaves the reservation disarmed if that event is a context switch, an interrupt, or a snoop to the load-linked's block.
- R10: After reset `rsp_valid` and `rsp_sc_ok` are 0 and no reservation is armed.
- R11: A store-conditional to an address other than the reserved one fails and does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr | input | 5 | Word address |
| req_wdata | input | 32 | Store data |
| ctx_switch | input | 1 | Context switch, clears reservation |
| irq_taken | input | 1 | Interrupt taken, clears reservation |
| snoop_valid | input | 1 | Remote write or invalidation observed |
| snoop_addr | input | 5 | Word address of the snooped access |
| rsp_valid | output | 1 | Response valid, one cycle after a request |
| rsp_rdata | output | 32 | Read data for load and load-linked |
| rsp_sc_ok | output | 1 | Store-conditional status, 1 = written |

## Verification
On every cycle, the assertions check the following properties. Any store-conditional, context switch or interrupt leaves the reservation disarmed. A clean load-linked arms it on its own address. A store-conditional against a disarmed reservation never reports success. Every request is answered in the next cycle. The bench scenarios must show whether memory actually kept or changed its contents after passing and failing store-conditionals. They must also show block-granular snoop matching, including the near-miss block, and the same-cycle races between a snoop and a store-conditional.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LL    = 2'b10,
    OP_SC    = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_word_mem.sv
module llsc_word_mem #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
    rdata <= store_q[addr];
  end
endmodule

// File: rtl/llsc_link_reg.sv
module llsc_link_reg
  import llsc_pkg::*;
#(
  parameter int AW = 5,
  parameter int BLK_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  llsc_op_e      req_op,
  input  logic [AW-1:0] req_addr,
  input  logic          ctx_switch,
  input  logic          irq_taken,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          sc_pass,
  output logic          link_valid,
  output logic [AW-1:0] link_addr
);
  localparam int TAG_W = AW - BLK_BITS;

  logic is_ll, is_sc, snoop_hit_link, snoop_hit_req, drop_link, drop_new;

  assign is_ll = req_valid && (req_op == OP_LL);
  assign is_sc = req_valid && (req_op == OP_SC);
  assign snoop_hit_link = snoop_valid &&
    (snoop_addr[AW-1:BLK_BITS] == link_addr[AW-1:BLK_BITS]);
  assign snoop_hit_req  = snoop_valid &&
    (snoop_addr[AW-1:BLK_BITS] == req_addr[AW-1:BLK_BITS]);
  assign drop_link = ctx_switch || irq_taken || snoop_hit_link;
  assign drop_new  = ctx_switch || irq_taken || snoop_hit_req;
  assign sc_pass = is_sc && link_valid && (link_addr == req_addr) && !drop_link;

  always_ff @(posedge clk) begin
    if (rst) begin
      link_valid <= 1'b0;
      link_addr  <= '0;
    end else if (is_ll) begin
      link_valid <= !drop_new;
      link_addr  <= req_addr;
    end else if (is_sc || drop_link) begin
      link_valid <= 1'b0;
    end
  end

  p_sc_consumes_r5: assert property (@(posedge clk) disable iff (rst)
    is_sc |=> !link_valid);
  p_ctx_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (ctx_switch && !is_ll) |=> !link_valid);
  p_irq_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (irq_taken && !is_ll) |=> !link_valid);
  p_ll_arms_r1: assert property (@(posedge clk) disable iff (rst)
    (is_ll && !ctx_switch && !irq_taken && !snoop_valid)
      |=> (link_valid && link_addr == $past(req_addr)));
  p_no_pass_unarmed_r4: assert property (@(posedge clk) disable iff (rst)
    !link_valid |-> !sc_pass);

  logic [TAG_W-1:0] unused_tag;
  assign unused_tag = link_addr[AW-1:BLK_BITS];
endmodule

// File: rtl/llsc_monitor_top.sv
module llsc_monitor_top
  import llsc_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 32,
  parameter int BLK_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ctx_switch,
  input  logic          irq_taken,
  input  logic          snoop_valid,
  input  logic [AW-1:0] snoop_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_sc_ok
);
  llsc_op_e      op;
  logic          sc_pass, mem_we, link_valid;
  logic [AW-1:0] link_addr;

  assign op = llsc_op_e'(req_op);
  assign mem_we = req_valid && ((op == OP_STORE) || sc_pass);

  llsc_link_reg #(.AW(AW), .BLK_BITS(BLK_BITS)) u_link (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(op),
    .req_addr(req_addr), .ctx_switch(ctx_switch), .irq_taken(irq_taken),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .sc_pass(sc_pass), .link_valid(link_valid), .link_addr(link_addr)
  );

  llsc_word_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(mem_we), .addr(req_addr), .wdata(req_wdata),
    .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_sc_ok <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_sc_ok <= sc_pass;
    end
  end

  p_rsp_next_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_sc_fail_unarmed_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_SC && !link_valid) |=> !rsp_sc_ok);
  p_sc_addr_miss_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_SC && link_addr != req_addr) |=> !rsp_sc_ok);
  p_snoop_race_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && op == OP_SC && snoop_valid &&
     snoop_addr[AW-1:BLK_BITS] == req_addr[AW-1:BLK_BITS]) |=> !rsp_sc_ok);
endmodule

// File: tb/llsc_monitor_top_test.sv
module llsc_monitor_top_test;
  logic        clk = 0, rst = 1;
  logic        req_valid = 0;
  logic [1:0]  req_op = 0;
  logic [4:0]  req_addr = 0, snoop_addr = 0;
  logic [31:0] req_wdata = 0;
  logic        ctx_switch = 0, irq_taken = 0, snoop_valid = 0;
  logic        rsp_valid, rsp_sc_ok;
  logic [31:0] rsp_rdata;

  int checks = 0, errors = 0;
  logic [31:0] m_mem [32];
  logic        m_lv = 0;
  logic [4:0]  m_la = 0;

  always #10 clk = ~clk;

  llsc_monitor_top uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic same_blk(input logic [4:0] a, input logic [4:0] b);
    return a[4:2] == b[4:2];
  endfunction

  task automatic req(input logic [1:0] op, input logic [4:0] a, input logic [31:0] d,
                     input logic cs, input logic it, input logic sv, input logic [4:0] sa,
                     input string tag);
    logic pass, kill_old, kill_new;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    ctx_switch = cs; irq_taken = it; snoop_valid = sv; snoop_addr = sa;
    kill_old = cs || it || (sv && same_blk(sa, m_la));
    kill_new = cs || it || (sv && same_blk(sa, a));
    pass = (op == 2'b11) && m_lv && (m_la == a) && !kill_old;
    @(posedge clk); #1;
    chk({tag, " rsp_valid"}, {31'd0, rsp_valid}, 32'd1);
    if (op == 2'b00 || op == 2'b10) chk({tag, " rdata"}, rsp_rdata, m_mem[a]);
    if (op == 2'b11) chk({tag, " sc_ok"}, {31'd0, rsp_sc_ok}, {31'd0, pass});
    if (op == 2'b01 || pass) m_mem[a] = d;
    if (op == 2'b10) begin m_lv = !kill_new; m_la = a; end
    else if (op == 2'b11 || kill_old) m_lv = 0;
    req_valid = 0; ctx_switch = 0; irq_taken = 0; snoop_valid = 0;
  endtask

  task automatic idle(input logic cs, input logic it, input logic sv, input logic [4:0] sa);
    @(negedge clk);
    ctx_switch = cs; irq_taken = it; snoop_valid = sv; snoop_addr = sa;
    if (cs || it || (sv && same_blk(sa, m_la))) m_lv = 0;
    @(posedge clk); #1;
    ctx_switch = 0; irq_taken = 0; snoop_valid = 0;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R10 sc_ok", {31'd0, rsp_sc_ok}, 0);
    @(negedge clk); rst = 0;
    req(2'b11, 5'd3, 32'hDEAD, 0, 0, 0, 0, "R10 sc after reset");
    for (int i = 0; i < 32; i++) req(2'b01, 5'(i), 32'h1000 + i, 0, 0, 0, 0, "R2 init");
    req(2'b00, 5'd3, 0, 0, 0, 0, 0, "R4 mem kept R2 load");
    // R1 / R3 success path
    req(2'b10, 5'd5, 0, 0, 0, 0, 0, "R1 ll");
    req(2'b11, 5'd5, 32'hA5A5, 0, 0, 0, 0, "R3 sc pass");
    req(2'b00, 5'd5, 0, 0, 0, 0, 0, "R3 written");
    // R5 second sc fails
    req(2'b11, 5'd5, 32'hBEEF, 0, 0, 0, 0, "R5 second sc");
    req(2'b00, 5'd5, 0, 0, 0, 0, 0, "R4 no write");
    // R2 plain store keeps reservation
    req(2'b10, 5'd6, 0, 0, 0, 0, 0, "R1 ll");
    req(2'b01, 5'd6, 32'h77, 0, 0, 0, 0, "R2 store");
    req(2'b11, 5'd6, 32'h78, 0, 0, 0, 0, "R2 sc after store");
    // R6, R7
    req(2'b10, 5'd7, 0, 0, 0, 0, 0, "R1 ll");
    idle(1, 0, 0, 0);
    req(2'b11, 5'd7, 32'h1, 0, 0, 0, 0, "R6 ctx");
    req(2'b10, 5'd7, 0, 0, 0, 0, 0, "R1 ll");
    idle(0, 1, 0, 0);
    req(2'b11, 5'd7, 32'h2, 0, 0, 0, 0, "R7 irq");
    // R8 snoop same block vs other block
    req(2'b10, 5'd9, 0, 0, 0, 0, 0, "R1 ll");
    idle(0, 0, 1, 5'd12);
    req(2'b11, 5'd9, 32'h3, 0, 0, 0, 0, "R8 other blk");
    req(2'b10, 5'd9, 0, 0, 0, 0, 0, "R1 ll");
    idle(0, 0, 1, 5'd11);
    req(2'b11, 5'd9, 32'h4, 0, 0, 0, 0, "R8 same blk");
    // R9 races
    req(2'b10, 5'd17, 0, 0, 0, 0, 0, "R1 ll");
    req(2'b11, 5'd17, 32'h5, 0, 0, 1, 5'd16, "R9 sc race");
    req(2'b00, 5'd17, 0, 0, 0, 0, 0, "R9 no write");
    req(2'b10, 5'd18, 0, 0, 1, 0, 0, "R9 ll with irq");
    req(2'b11, 5'd18, 32'h6, 0, 0, 0, 0, "R9 sc after ll+irq");
    // R11 address mismatch
    req(2'b10, 5'd20, 0, 0, 0, 0, 0, "R1 ll");
    req(2'b11, 5'd21, 32'h7, 0, 0, 0, 0, "R11 sc miss");
    req(2'b00, 5'd21, 0, 0, 0, 0, 0, "R11 no write");
    // Random mix
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r = $urandom;
      req(2'(r[1:0]), {3'd0, r[3:2]} + 5'(r[5:4] * 8), $urandom,
          r[12:8] == 0, r[17:13] == 0, r[21:19] == 0, 5'(r[26:22]), "R3 R4 random");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule